// File: doc/BRIEF.md
# I2C Register-File Slave

This block gives an I2C host read and write access to a small bank of 8-bit configuration registers. It samples SCL and SDA with a fast system clock. Each line passes through a two-flop synchronizer and a glitch filter. The block then finds start, repeated-start and stop conditions and shifts bytes in and out MSB first. SDA is never driven high: the block has one output enable, and when that enable is high the pad pulls the line low.

A transaction opens with the 7-bit device address and a direction bit. A strap input sets bit A1 of the 8-bit address byte, so one board can carry two of these slaves. After a write address, the next byte loads a subaddress pointer. Later bytes write registers at that pointer, and the pointer moves up by one after each byte. To read, the host writes the subaddress, sends a repeated start and then sends the read address. Bytes then come from the pointed register, again with the pointer moving up after each byte. Behaviour at the top of the register map is defined:

- A read that runs past the top keeps returning the highest register.
- A write that runs past the top is refused.

Every accepted write also appears on a one-cycle strobe with its address and data, so neighbouring logic can react to it.

Top module: `i2c_regfile_slave`

## Requirements
- R1: The slave acknowledges (SDA low on the ninth clock) the address byte 0xD4 (write) or 0xD5 (read) when `addr_strap` is 0, and 0xD6 or 0xD7 when it is 1. Bit 0 of the address byte is the direction: 0 means the host writes, 1 means the host reads. Data bits are sent MSB first.
- R2: An address byte that does not match is not acknowledged. The slave then ignores the bus, writing nothing and acknowledging nothing, until the next start.
- R3: A subaddress byte below `NUM_REGS` is acknowledged. A subaddress of `NUM_REGS` or above gets a no-acknowledge, and the slave goes idle, so following bytes are neither acknowledged nor written.
- R4: Each data byte in a write is stored at the pointer and acknowledged. `wr_strobe` pulses for one cycle with `wr_addr` and `wr_data`, and the pointer then moves up by one.
- R5: After the host writes a subaddress, sends a repeated start and then sends the read address, the slave returns the registers from that subaddress upward, one per byte.
- R6: A read that passes the highest subaddress (`NUM_REGS`-1) keeps returning that register until the host sends a no-acknowledge.
- R7: In a write, the byte that follows the one stored at the highest subaddress gets a no-acknowledge and is not stored. The slave then goes idle.
- R8: A stop in the middle of a byte sends the slave to idle with nothing written. A start in the middle of a byte restarts address reception.
- R9: After reset, register 0x00 holds 0x12, every other register holds 0x00, and `sda_oe` and `wr_strobe` are low.
- R10: `sda_oe` changes only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| addr_strap | input | 1 | Sets bit A1 of the device address |
| wr_strobe | output | 1 | One-cycle pulse for each stored byte |
| wr_addr | output | 8 | Register index of the stored byte |
| wr_data | output | 8 | Value of the stored byte |

## Verification
A bus condition and the end of a byte are decided on the same filtered-SCL edge logic. So a stop or a start can arrive in the cycle where a half-received byte would otherwise move on towards its commit. The bench provokes this in two ways: it ends a data byte with a stop after four bits, and it cuts another byte with a repeated start after three bits. The result is judged at the ports. No write strobe may appear, a read-back of the register must show its old value, and the new address after the repeated start must be acknowledged. Pointer overflow also falls on a byte that would otherwise commit. The bench checks it by counting strobes and by reading back the top registers.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_SUB,
        ST_SUB,
        ST_ACK_WR,
        ST_WDATA,
        ST_ACK_RD,
        ST_RDATA,
        ST_RACK
    } i2cs_state_e;

    typedef struct packed {
        i2cs_state_e state;
        logic [3:0]  cnt;    // bits shifted in the current byte
        logic [7:0]  shreg;  // receive or transmit shift register
        logic [7:0]  ptr;    // subaddress pointer
        logic        past;   // pointer already ran beyond the top on writes
        logic        oe;     // open-drain pull-down enable
    } i2cs_ctx_t;

endpackage

// File: rtl/i2cs_line_filter.sv
module i2cs_line_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic          s1_q, s2_q, out_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q  <= 1'b1;
            s2_q  <= 1'b1;
            out_q <= 1'b1;
            cnt_q <= '0;
        end else begin
            s1_q <= line_i;
            s2_q <= s1_q;
            if (s2_q != out_q) begin
                if (cnt_q == CW'(FILT_LEN - 1)) begin
                    out_q <= s2_q;
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                cnt_q <= '0;
            end
        end
    end

    assign line_o = out_q;
endmodule

// File: rtl/i2cs_bus_events.sv
module i2cs_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic scl_prev_q, sda_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= scl_f;
            sda_prev_q <= sda_f;
        end
    end

    assign scl_rise  = scl_f & ~scl_prev_q;
    assign scl_fall  = ~scl_f & scl_prev_q;
    assign bus_start = scl_f & scl_prev_q & sda_prev_q & ~sda_f;
    assign bus_stop  = scl_f & scl_prev_q & ~sda_prev_q & sda_f;
endmodule

// File: rtl/i2cs_regbank.sv
module i2cs_regbank #(
    parameter int          NUM_REGS = 16,
    parameter logic [7:0]  REG0_RST = 8'h12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_idx,
    input  logic [7:0] wr_val,
    input  logic [7:0] rd_idx,
    output logic [7:0] rd_val
);
    logic [NUM_REGS*8-1:0] flat;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam logic [7:0] RV = (i == 0) ? REG0_RST : 8'h00;
        logic [7:0] val_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                            val_q <= RV;
            else if (wr_en && wr_idx == 8'(i))     val_q <= wr_val;
        end
        assign flat[i*8 +: 8] = val_q;
    end

    always_comb begin
        rd_val = 8'h00;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx == 8'(i)) rd_val = flat[i*8 +: 8];
        end
    end
endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave
    import i2cs_pkg::*;
#(
    parameter int         NUM_REGS = 16,
    parameter logic [6:0] DEV_BASE = 7'h6A,
    parameter logic [7:0] REG0_RST = 8'h12,
    parameter int         FILT_LEN = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic       addr_strap,
    output logic       wr_strobe,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data
);
    localparam logic [7:0] MAX_SUB = 8'(NUM_REGS - 1);
    localparam logic [8:0] NREG9   = 9'(NUM_REGS);

    logic [1:0] line_raw, line_flt;
    logic       scl_flt, sda_flt;
    logic       evt_rise, evt_fall, evt_start, evt_stop;
    logic [7:0] rd_data, dev_addr_unused;
    logic [6:0] dev_addr;
    i2cs_ctx_t  d, q;
    i2cs_state_e cur_state;
    logic       we_d;
    logic [7:0] wa_d, wdat_d;

    assign line_raw = {sda_i, scl_i};
    for (genvar k = 0; k < 2; k++) begin : g_line
        i2cs_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk(clk), .rst_n(rst_n), .line_i(line_raw[k]), .line_o(line_flt[k])
        );
    end
    assign scl_flt = line_flt[0];
    assign sda_flt = line_flt[1];

    i2cs_bus_events u_evt (
        .clk(clk), .rst_n(rst_n), .scl_f(scl_flt), .sda_f(sda_flt),
        .scl_rise(evt_rise), .scl_fall(evt_fall),
        .bus_start(evt_start), .bus_stop(evt_stop)
    );

    assign dev_addr        = {DEV_BASE[6:1], addr_strap};
    assign dev_addr_unused = 8'h00;

    always_comb begin
        d      = q;
        we_d   = 1'b0;
        wa_d   = q.ptr;
        wdat_d = q.shreg;
        if (evt_start) begin
            d.state = ST_ADDR;
            d.cnt   = '0;
            d.oe    = 1'b0;
        end else if (evt_stop) begin
            d.state = ST_IDLE;
            d.oe    = 1'b0;
        end else begin
            unique case (q.state)
                ST_ADDR, ST_SUB, ST_WDATA: begin
                    if (evt_rise && q.cnt != 4'd8) begin
                        d.shreg = {q.shreg[6:0], sda_flt};
                        d.cnt   = q.cnt + 4'd1;
                    end else if (evt_fall && q.cnt == 4'd8) begin
                        d.cnt   = '0;
                        d.state = ST_IDLE;
                        if (q.state == ST_ADDR) begin
                            if (q.shreg[7:1] == dev_addr) begin
                                d.oe    = 1'b1;
                                d.state = q.shreg[0] ? ST_ACK_RD : ST_ACK_SUB;
                            end
                        end else if (q.state == ST_SUB) begin
                            if ({1'b0, q.shreg} < NREG9) begin
                                d.oe    = 1'b1;
                                d.ptr   = q.shreg;
                                d.past  = 1'b0;
                                d.state = ST_ACK_WR;
                            end
                        end else if (!q.past) begin
                            we_d    = 1'b1;
                            d.oe    = 1'b1;
                            d.state = ST_ACK_WR;
                            if (q.ptr == MAX_SUB) d.past = 1'b1;
                            else                  d.ptr  = q.ptr + 8'd1;
                        end
                    end
                end
                ST_ACK_SUB: if (evt_fall) begin
                    d.oe    = 1'b0;
                    d.state = ST_SUB;
                end
                ST_ACK_WR: if (evt_fall) begin
                    d.oe    = 1'b0;
                    d.state = ST_WDATA;
                end
                ST_ACK_RD: if (evt_fall) begin
                    d.shreg = rd_data;
                    d.oe    = ~rd_data[7];
                    d.cnt   = '0;
                    d.state = ST_RDATA;
                end
                ST_RDATA: begin
                    if (evt_rise && q.cnt != 4'd8) begin
                        d.cnt = q.cnt + 4'd1;
                    end else if (evt_fall) begin
                        if (q.cnt == 4'd8) begin
                            d.oe    = 1'b0;
                            d.state = ST_RACK;
                        end else if (q.cnt != 4'd0) begin
                            d.shreg = {q.shreg[6:0], 1'b0};
                            d.oe    = ~q.shreg[6];
                        end
                    end
                end
                ST_RACK: if (evt_rise) begin
                    if (!sda_flt) begin
                        d.state = ST_ACK_RD;
                        if (q.ptr != MAX_SUB) d.ptr = q.ptr + 8'd1;
                    end else begin
                        d.state = ST_IDLE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, cnt: '0, shreg: '0, ptr: '0, past: 1'b0, oe: 1'b0};
        end else begin
            q <= d;
        end
    end

    i2cs_regbank #(.NUM_REGS(NUM_REGS), .REG0_RST(REG0_RST)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(we_d), .wr_idx(wa_d), .wr_val(wdat_d),
        .rd_idx(q.ptr), .rd_val(rd_data)
    );

    assign cur_state = q.state;
    assign sda_oe    = q.oe;
    assign wr_strobe = we_d;
    assign wr_addr   = we_d ? wa_d : dev_addr_unused;
    assign wr_data   = we_d ? wdat_d : dev_addr_unused;
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker
    import i2cs_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        scl_f,
    input logic        ev_start,
    input logic        ev_stop,
    input i2cs_state_e state,
    input logic        sda_oe,
    input logic        wr_strobe,
    input logic [7:0]  wr_addr
);
    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_f);  // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |-> !sda_oe);  // R2
    AST_STROBE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |=> !wr_strobe);  // R4
    AST_STROBE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |=> sda_oe);  // R4
    AST_WR_IN_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |-> {1'b0, wr_addr} < 9'(NUM_REGS));  // R7
    AST_START_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start |=> state == ST_ADDR);  // R8
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop && !ev_start |=> state == ST_IDLE);  // R8
endmodule

bind i2c_regfile_slave i2cs_checker #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_flt), .ev_start(evt_start),
    .ev_stop(evt_stop), .state(cur_state), .sda_oe(sda_oe),
    .wr_strobe(wr_strobe), .wr_addr(wr_addr)
);

// File: tb/test_i2c_regfile_slave.sv
`timescale 1ns/1ps
module test_i2c_regfile_slave;
    localparam int Q = 12;

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1, strap = 1'b0;
    logic sda_oe, wr_strobe;
    logic [7:0] wr_addr, wr_data;
    logic sda_line;
    int n_checks = 0, n_fail = 0;
    int n_strobe = 0, oe_viol = 0;
    logic [7:0] last_wa = 0, last_wd = 0;
    logic oe_prev = 1'b0;

    assign sda_line = sda_m & ~sda_oe;
    always #10 clk = ~clk;

    i2c_regfile_slave i_i2c_regfile_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .addr_strap(strap), .wr_strobe(wr_strobe),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    always @(negedge clk) begin
        if (wr_strobe) begin
            n_strobe++;
            last_wa = wr_addr;
            last_wd = wr_data;
        end
        if (rst_n && sda_oe !== oe_prev && scl_m) oe_viol++;
        oe_prev = sda_oe;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        wq(Q); sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(2*Q);
        sda_m = 1'b0; wq(2*Q); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(2*Q);
        sda_m = 1'b1; wq(2*Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            wq(Q); sda_m = b[i]; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0;
        end
    endtask

    task automatic wbyte(input logic [7:0] b, output logic acked);
        send_bits(b, 8);
        wq(Q); sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
        acked = !sda_line;
        wq(Q); scl_m = 1'b0;
    endtask

    task automatic rbyte(input logic nack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(2*Q); scl_m = 1'b1; wq(Q); b[i] = sda_line; wq(Q); scl_m = 1'b0;
        end
        wq(Q); sda_m = nack; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0;
        wq(2); sda_m = 1'b1;
    endtask

    task automatic t_reset();
        logic a; logic [7:0] v;
        chk("R9 sda_oe after reset", sda_oe, 0);
        chk("R9 wr_strobe after reset", wr_strobe, 0);
        bus_start(); wbyte(8'hD4, a); chk("R1 ack D4", a, 1);
        wbyte(8'h00, a); chk("R3 ack sub 00", a, 1);
        bus_start(); wbyte(8'hD5, a); chk("R1 ack D5", a, 1);
        rbyte(1'b0, v); chk("R9 reg00 reset", v, 8'h12);
        rbyte(1'b1, v); chk("R9 reg01 reset", v, 8'h00);
        bus_stop();
    endtask

    task automatic t_write_read();
        logic a; logic [7:0] v; int s0 = n_strobe;
        bus_start(); wbyte(8'hD4, a); wbyte(8'h02, a);
        wbyte(8'hA5, a); chk("R4 ack data A5", a, 1);
        wbyte(8'h3C, a); chk("R4 ack data 3C", a, 1);
        bus_stop();
        chk("R4 strobe count", n_strobe - s0, 2);
        chk("R4 strobe addr", last_wa, 8'h03);
        chk("R4 strobe data", last_wd, 8'h3C);
        bus_start(); wbyte(8'hD4, a); wbyte(8'h02, a);
        bus_start(); wbyte(8'hD5, a);
        rbyte(1'b0, v); chk("R5 read reg02", v, 8'hA5);
        rbyte(1'b1, v); chk("R5 read reg03", v, 8'h3C);
        bus_stop();
    endtask

    task automatic t_strap();
        logic a; logic [7:0] v;
        strap = 1'b1; wq(4);
        bus_start(); wbyte(8'hD4, a); chk("R1 D4 refused with strap 1", a, 0);
        bus_stop();
        bus_start(); wbyte(8'hD6, a); chk("R1 ack D6", a, 1);
        wbyte(8'h07, a); wbyte(8'h5A, a); bus_stop();
        bus_start(); wbyte(8'hD6, a); wbyte(8'h07, a);
        bus_start(); wbyte(8'hD7, a); chk("R1 ack D7", a, 1);
        rbyte(1'b1, v); chk("R1 read reg07 strap 1", v, 8'h5A);
        bus_stop();
        strap = 1'b0; wq(4);
    endtask

    task automatic t_foreign();
        logic a; int s0 = n_strobe;
        bus_start(); wbyte(8'hA0, a); chk("R2 foreign address", a, 0);
        wbyte(8'h01, a); chk("R2 byte after foreign", a, 0);
        wbyte(8'hFF, a); chk("R2 second byte after foreign", a, 0);
        bus_stop();
        chk("R2 no strobe", n_strobe - s0, 0);
    endtask

    task automatic t_bad_sub();
        logic a; int s0 = n_strobe;
        bus_start(); wbyte(8'hD4, a);
        wbyte(8'h10, a); chk("R3 sub 0x10 nack", a, 0);
        wbyte(8'h77, a); chk("R3 data after bad sub", a, 0);
        bus_stop();
        chk("R3 no strobe", n_strobe - s0, 0);
    endtask

    task automatic t_wr_overflow();
        logic a; int s0 = n_strobe;
        bus_start(); wbyte(8'hD4, a);
        wbyte(8'h0E, a); chk("R3 sub 0E ack", a, 1);
        wbyte(8'h11, a); chk("R4 ack 0E", a, 1);
        wbyte(8'h22, a); chk("R7 ack top 0F", a, 1);
        wbyte(8'h33, a); chk("R7 past top nack", a, 0);
        wbyte(8'h44, a); chk("R7 idle after overflow", a, 0);
        bus_stop();
        chk("R7 strobe count", n_strobe - s0, 2);
        chk("R7 last addr", last_wa, 8'h0F);
        chk("R7 last data", last_wd, 8'h22);
    endtask

    task automatic t_rd_overflow();
        logic a; logic [7:0] v;
        bus_start(); wbyte(8'hD4, a); wbyte(8'h0E, a);
        bus_start(); wbyte(8'hD5, a);
        rbyte(1'b0, v); chk("R6 reg0E", v, 8'h11);
        rbyte(1'b0, v); chk("R6 reg0F", v, 8'h22);
        rbyte(1'b0, v); chk("R6 repeat top 1", v, 8'h22);
        rbyte(1'b1, v); chk("R6 repeat top 2", v, 8'h22);
        bus_stop();
    endtask

    task automatic t_abort();
        logic a; logic [7:0] v; int s0 = n_strobe;
        bus_start(); wbyte(8'hD4, a); wbyte(8'h05, a);
        send_bits(8'hFF, 4); bus_stop();
        chk("R8 stop mid byte no strobe", n_strobe - s0, 0);
        bus_start(); wbyte(8'hD4, a); wbyte(8'h05, a);
        send_bits(8'hC3, 3);
        bus_start(); wbyte(8'hD4, a); chk("R8 ack after mid-byte start", a, 1);
        wbyte(8'h05, a);
        bus_start(); wbyte(8'hD5, a);
        rbyte(1'b1, v); chk("R8 reg05 untouched", v, 8'h00);
        bus_stop();
        chk("R8 no strobe overall", n_strobe - s0, 0);
    endtask

    initial begin
        wq(5); rst_n = 1'b1; wq(5);
        t_reset();
        t_write_read();
        t_strap();
        t_foreign();
        t_bad_sub();
        t_wr_overflow();
        t_rd_overflow();
        t_abort();
        chk("R10 sda_oe moved with SCL high", oe_viol, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule